// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the next control-memory address for a microprogrammed controller. It holds a control address register (CAR) that drives the control memory, and a single-entry return register that holds one subroutine return address. The control memory returns the current microinstruction. Three of its fields control the sequencer: a condition select, a branch type and a branch address. Together with the instruction opcode and a few status inputs, these fields set the next CAR value.

The 2-bit branch type chooses one of four operations: conditional jump, conditional call, map to the opcode's routine, or return. The condition select picks the test bit. Select 0 is a constant 1, which makes jumps and calls unconditional. Selects 1 to 3 pick one of three status inputs. A jump or call whose test bit is 0 falls through to CAR+1. A taken call also saves CAR+1 in the return register. The map operation gives each opcode a four-word routine slot in the lower half of the address space. Reset points CAR at the fetch routine in the upper half.

Top module: `mps_sequencer`

## Requirements
- R1: While rst is high at a rising clock edge, CAR loads RESET_ADDR (default 64) and the return register clears to 0.
- R2: With branch type 0 (jump) and a test bit of 1, CAR loads the branch address field at the next edge.
- R3: With branch type 0 or 1 and a test bit of 0, CAR loads CAR+1 at the next edge.
- R4: The test bit comes from condition select: select 0 is constant 1, and select k (1 to 3) is status_in[k-1].
- R5: With branch type 1 (call) and a test bit of 1, CAR loads the branch address and the return register captures CAR+1 in the same edge.
- R6: A call whose test bit is 0 leaves the return register unchanged.
- R7: Branch type 2 (map) loads CAR with {0, opcode[3:0], 00}, so the routine for opcode n starts at 4n.
- R8: Branch type 3 (return) loads CAR from the return register. Jump, map and return operations leave the return register unchanged.
- R9: CAR+1 wraps modulo 128, so 127 is followed by 0.
- R10: The return register holds one entry. A second taken call overwrites the first return address.
- R11: Map and return ignore the test bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode of the current machine instruction |
| status_in | input | 3 | Status inputs reached by condition selects 1 to 3 |
| cd_sel | input | 2 | Condition select field of the microinstruction |
| br_type | input | 2 | Branch type field: 0 jump, 1 call, 2 map, 3 return |
| br_addr | input | 7 | Branch address field of the microinstruction |
| car | output | 7 | Control address register, the address sent to control memory |

## Verification
The return register cannot be seen at the ports. Its contents show only when a return makes CAR jump to the saved address. Each scenario therefore ends a chain of calls, failed calls, maps or jumps with a return, and checks the CAR value that the return produces. The bench programs a small control-memory array that is indexed by CAR. This array leads the sequencer through a fetch, a map, a called subroutine and its return, both outcomes of a conditional jump, a nested call, and the wrap at address 127.

// File: rtl/mps_pkg.sv
package mps_pkg;

    // Branch-type field encoding; the input logic decodes these values
    typedef enum logic [1:0] {
        BR_JUMP = 2'b00,
        BR_CALL = 2'b01,
        BR_MAP  = 2'b10,
        BR_RET  = 2'b11
    } br_kind_e;

    // Source selected into the control address register
    typedef enum logic [1:0] {
        SRC_INC    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_MAP    = 2'b10,
        SRC_SBR    = 2'b11
    } car_src_e;

    typedef struct packed {
        car_src_e src;
        logic     save_ret;
    } seq_ctl_t;

    // Input logic: high select bit follows the branch type's high bit,
    // low select bit is the test for jump/call, or the low type bit otherwise.
    function automatic seq_ctl_t decode_ctl(input br_kind_e kind, input logic test);
        seq_ctl_t c;
        logic [1:0] k;
        k = kind;
        c.src      = car_src_e'({k[1], (~k[1] & test) | (k[1] & k[0])});
        c.save_ret = ~k[1] & k[0] & test;
        return c;
    endfunction

endpackage

// File: rtl/mps_cond_test.sv
module mps_cond_test #(
    parameter int CD_W = 2
) (
    input  logic [(1<<CD_W)-2:0] status_in,
    input  logic [CD_W-1:0]      cd_sel,
    output logic                 test
);
    localparam int N_COND = 1 << CD_W;

    logic [N_COND-1:0] cond_vec;

    // Entry 0 is the always-true condition
    assign cond_vec[0] = 1'b1;

    generate
        for (genvar i = 1; i < N_COND; i++) begin : g_cond
            assign cond_vec[i] = status_in[i-1];
        end
    endgenerate

    assign test = cond_vec[cd_sel];

endmodule

// File: rtl/mps_input_logic.sv
module mps_input_logic
    import mps_pkg::*;
(
    input  logic [1:0] br_type,
    input  logic       test,
    output seq_ctl_t   ctl
);
    br_kind_e kind;

    assign kind = br_kind_e'(br_type);

    always_comb begin
        ctl = decode_ctl(kind, test);
    end

endmodule

// File: rtl/mps_addr_path.sv
module mps_addr_path
    import mps_pkg::*;
#(
    parameter int          AW         = 7,
    parameter int          OP_W       = 4,
    parameter logic [AW-1:0] RESET_ADDR = 7'd64
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_ctl_t      ctl,
    input  logic [AW-1:0] br_addr,
    input  logic [OP_W-1:0] opcode,
    output logic [AW-1:0] car_q,
    output logic [AW-1:0] sbr_q
);
    // Routine slot width left below the opcode bits after the leading zero
    localparam int SLOT_W = AW - 1 - OP_W;

    logic [AW-1:0] car_inc;
    logic [AW-1:0] map_addr;
    logic [AW-1:0] car_d;

    assign car_inc = car_q + AW'(1);

    generate
        if (SLOT_W > 0) begin : g_slot
            assign map_addr = {1'b0, opcode, {SLOT_W{1'b0}}};
        end else begin : g_noslot
            assign map_addr = {1'b0, opcode};
        end
    endgenerate

    always_comb begin
        unique case (ctl.src)
            SRC_INC:    car_d = car_inc;
            SRC_BRANCH: car_d = br_addr;
            SRC_MAP:    car_d = map_addr;
            SRC_SBR:    car_d = sbr_q;
            default:    car_d = car_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= RESET_ADDR;
            sbr_q <= '0;
        end else begin
            car_q <= car_d;
            if (ctl.save_ret) begin
                sbr_q <= car_inc;
            end
        end
    end

endmodule

// File: rtl/mps_sequencer.sv
module mps_sequencer
    import mps_pkg::*;
#(
    parameter int            AW         = 7,
    parameter int            OP_W       = 4,
    parameter int            CD_W       = 2,
    parameter logic [AW-1:0] RESET_ADDR = 7'd64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OP_W-1:0]      opcode,
    input  logic [(1<<CD_W)-2:0] status_in,
    input  logic [CD_W-1:0]      cd_sel,
    input  logic [1:0]           br_type,
    input  logic [AW-1:0]        br_addr,
    output logic [AW-1:0]        car
);
    logic     test;
    seq_ctl_t ctl;
    logic [AW-1:0] sbr_q;

    mps_cond_test #(.CD_W(CD_W)) i_cond (
        .status_in (status_in),
        .cd_sel    (cd_sel),
        .test      (test)
    );

    mps_input_logic i_inlog (
        .br_type (br_type),
        .test    (test),
        .ctl     (ctl)
    );

    mps_addr_path #(
        .AW         (AW),
        .OP_W       (OP_W),
        .RESET_ADDR (RESET_ADDR)
    ) i_path (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .br_addr (br_addr),
        .opcode  (opcode),
        .car_q   (car),
        .sbr_q   (sbr_q)
    );

endmodule

// File: rtl/mps_sequencer_chk.sv
module mps_sequencer_chk #(
    parameter int            AW         = 7,
    parameter int            OP_W       = 4,
    parameter int            CD_W       = 2,
    parameter logic [AW-1:0] RESET_ADDR = 7'd64
) (
    input logic                 clk,
    input logic                 rst,
    input logic [OP_W-1:0]      opcode,
    input logic [(1<<CD_W)-2:0] status_in,
    input logic [CD_W-1:0]      cd_sel,
    input logic [1:0]           br_type,
    input logic [AW-1:0]        br_addr,
    input logic [AW-1:0]        car,
    input logic [AW-1:0]        sbr
);
    logic t_ref;

    always_comb begin
        if (cd_sel == '0) t_ref = 1'b1;
        else              t_ref = status_in[cd_sel - CD_W'(1)];
    end

    assert_reset_addr_R1: assert property (@(posedge clk)
        rst |=> (car == RESET_ADDR && sbr == '0));

    assert_jump_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (br_type == 2'b00 && t_ref) |=> car == $past(br_addr));

    assert_fall_through_R3: assert property (@(posedge clk) disable iff (rst)
        (!br_type[1] && !t_ref) |=> car == AW'($past(car) + AW'(1)));

    assert_call_saves_R5: assert property (@(posedge clk) disable iff (rst)
        (br_type == 2'b01 && t_ref) |=> (sbr == AW'($past(car) + AW'(1)) && car == $past(br_addr)));

    assert_sbr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(br_type == 2'b01 && t_ref) |=> $stable(sbr));

    assert_map_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (br_type == 2'b10) |=> car == {1'b0, $past(opcode), 2'b00});

    assert_return_R8: assert property (@(posedge clk) disable iff (rst)
        (br_type == 2'b11) |=> car == $past(sbr));

endmodule

bind mps_sequencer mps_sequencer_chk #(
    .AW         (AW),
    .OP_W       (OP_W),
    .CD_W       (CD_W),
    .RESET_ADDR (RESET_ADDR)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .opcode    (opcode),
    .status_in (status_in),
    .cd_sel    (cd_sel),
    .br_type   (br_type),
    .br_addr   (br_addr),
    .car       (car),
    .sbr       (sbr_q)
);

// File: tb/test_mps_sequencer.sv
`timescale 1ns/1ps
module test_mps_sequencer;

    typedef struct packed {
        logic [1:0] cd;
        logic [1:0] br;
        logic [6:0] ad;
    } uword_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'd0;
    logic [2:0] status_in = 3'd0;
    logic [1:0] cd_sel;
    logic [1:0] br_type;
    logic [6:0] br_addr;
    logic [6:0] car;

    uword_t rom [0:127];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mps_sequencer i_mps_sequencer (
        .clk       (clk),
        .rst       (rst),
        .opcode    (opcode),
        .status_in (status_in),
        .cd_sel    (cd_sel),
        .br_type   (br_type),
        .br_addr   (br_addr),
        .car       (car)
    );

    // Control-memory model indexed by CAR
    always_comb begin
        cd_sel  = rom[car].cd;
        br_type = rom[car].br;
        br_addr = rom[car].ad;
    end

    task automatic check(input logic [6:0] exp, input string tag);
        total++;
        if (car !== exp) begin
            bad++;
            $display("FAIL %s: car=%0d expected=%0d", tag, car, exp);
        end
    endtask

    task automatic step_check(input logic [6:0] exp, input string tag);
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    // Fill with conditional jumps on status input 1 (kept 0 here: increment)
    task automatic clear_rom();
        for (int i = 0; i < 128; i++) rom[i] = '{cd: 2'd1, br: 2'b00, ad: 7'd0};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        status_in = 3'd0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(7'd64, "R1 reset address");
    endtask

    // Fetch, call, subroutine, return, map, taken jump
    task automatic t_main_trace();
        clear_rom();
        rom[64] = '{cd: 2'd2, br: 2'b00, ad: 7'd100}; // status_in[1]=0: not taken
        rom[65] = '{cd: 2'd0, br: 2'b01, ad: 7'd96};  // unconditional call
        rom[96] = '{cd: 2'd1, br: 2'b00, ad: 7'd0};   // not taken
        rom[97] = '{cd: 2'd0, br: 2'b11, ad: 7'd0};   // return
        rom[66] = '{cd: 2'd0, br: 2'b10, ad: 7'd0};   // map
        rom[20] = '{cd: 2'd3, br: 2'b00, ad: 7'd64};  // status_in[2]=1: taken
        opcode = 4'd5;
        do_reset();
        status_in = 3'b100;
        step_check(7'd65, "R3 R4 jump not taken");
        step_check(7'd96, "R5 call taken");
        step_check(7'd97, "R3 fall through in subroutine");
        step_check(7'd66, "R8 return to call+1");
        step_check(7'd20, "R7 map opcode 5");
        step_check(7'd64, "R2 R4 jump taken on status 3");
    endtask

    task automatic t_call_not_taken();
        clear_rom();
        rom[64] = '{cd: 2'd1, br: 2'b01, ad: 7'd100};
        rom[65] = '{cd: 2'd0, br: 2'b11, ad: 7'd0};
        do_reset();
        status_in = 3'b110;
        step_check(7'd65, "R3 R4 call not taken");
        step_check(7'd0,  "R6 R1 return register untouched");
    endtask

    task automatic t_overwrite();
        clear_rom();
        rom[64] = '{cd: 2'd0, br: 2'b01, ad: 7'd80};
        rom[80] = '{cd: 2'd0, br: 2'b01, ad: 7'd90};
        rom[90] = '{cd: 2'd0, br: 2'b11, ad: 7'd0};
        rom[81] = '{cd: 2'd0, br: 2'b11, ad: 7'd0};
        do_reset();
        step_check(7'd80, "R5 first call");
        step_check(7'd90, "R5 second call");
        step_check(7'd81, "R10 return to latest call");
        step_check(7'd81, "R8 R10 return keeps register");
    endtask

    task automatic t_wrap();
        clear_rom();
        rom[64] = '{cd: 2'd0, br: 2'b00, ad: 7'd126};
        do_reset();
        step_check(7'd126, "R2 R4 unconditional jump");
        step_check(7'd127, "R3 increment");
        step_check(7'd0,   "R9 wrap to 0");
    endtask

    task automatic t_ignore_test();
        clear_rom();
        rom[64]  = '{cd: 2'd0, br: 2'b01, ad: 7'd100};
        rom[100] = '{cd: 2'd2, br: 2'b10, ad: 7'd5};
        rom[60]  = '{cd: 2'd3, br: 2'b11, ad: 7'd9};
        opcode = 4'd15;
        do_reset();
        status_in = 3'b000;
        step_check(7'd100, "R5 call");
        step_check(7'd60,  "R7 R11 map with false test");
        step_check(7'd65,  "R8 R11 return with false test after map");
    endtask

    initial begin
        clear_rom();
        t_main_trace();
        t_call_not_taken();
        t_overwrite();
        t_wrap();
        t_ignore_test();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: car=%0d expected=finish", car);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule